// File: doc/BRIEF.md
# I2C Random-Read Master

This block is a bus master for a two-wire serial bus. It performs an atomic random read from a serial memory device on a bus that other masters may share. One request sets the memory device's internal pointer and then reads one or more bytes starting at that pointer. The whole transfer is one uninterrupted bus transaction. The direction changes from transmit to receive through a repeated start, so no other master can move the pointer between the two phases.

Both lines are open-drain. The block pulls a line low by raising its enable output, and it reads the resolved line level back on its inputs. The inputs pass through a two-flop synchroniser before use.

A bus monitor follows START and STOP conditions on the lines, so the block can tell when another master owns the bus. While the block transmits, it compares each released bit with the line. A mismatch means arbitration is lost, and the block withdraws at once. Each read byte is presented with a one-cycle strobe. Completion, a missing acknowledge and lost arbitration are each reported with a one-cycle pulse.

Top module: `i2c_rr_master`

## Requirements
- R1: After reset, both line enables are 0 (lines released), `ready_o` is 1 and no status pulse is active. Whenever `ready_o` is 1, both enables are 0.
- R2: A request produces, in order: START, device address with R/W bit 0, ACK, word-address byte, ACK, repeated START, device address with R/W bit 1, ACK, the data bytes, and one STOP. There is no STOP between the write phase and the read phase, so a good transfer shows exactly two START conditions and one STOP. Address bytes are sent MSB first as {addr[6:0], rw}, and ACK is SDA low.
- R3: The block returns `nbytes_i` bytes, read from consecutive memory locations starting at `word_addr_i`. Each byte appears on `rd_data_o` with a one-cycle `rd_valid_o` pulse. A count of 0 is treated as 1. `rd_valid_o`, `done_o` and `arb_lost_o` are never high together.
- R4: In the read phase, the master drives ACK (SDA low) after every byte except the last one. After the last byte it leaves SDA high (NACK) and then issues STOP.
- R5: If the slave leaves SDA high in the acknowledge slot of the device address or of the word address, the block issues a STOP and skips the read phase. It then pulses `done_o` and `nack_o` together, and no `rd_valid_o` occurs.
- R6: If the block releases SDA during a transmitted bit and samples SDA low while SCL is high, it has lost arbitration. In that case it releases both lines in the same cycle and pulses `arb_lost_o` without `done_o`. It issues no STOP.
- R7: If another master drives exactly the same bits during the transfer, the block does not detect arbitration loss, and the read completes normally.
- R8: The block changes SDA only while it holds SCL low. The exceptions are START, repeated START and STOP symbols, and the arbitration-loss release.
- R9: During a transfer, consecutive rising edges of SCL are 4*`QDIV` clock cycles apart.
- R10: A request on `start_i` is taken only when the block is idle and the bus is free. The bus is free when a STOP has been seen since the last START, or when no START has been seen since reset. While the bus is not free, `ready_o` is 0 and `start_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when `ready_o` is 1 |
| dev_addr_i | input | 7 | Seven-bit device address |
| word_addr_i | input | 8 | Memory location of the first byte to read |
| nbytes_i | input | CNT_W | Number of bytes to read (0 counts as 1) |
| ready_o | output | 1 | Block idle and bus free |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe_o | output | 1 | Pulls SCL low when 1 |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| rd_data_o | output | 8 | Last byte received |
| rd_valid_o | output | 1 | One-cycle strobe for `rd_data_o` |
| done_o | output | 1 | One-cycle pulse when the STOP completes |
| nack_o | output | 1 | With `done_o`: an address or word byte was not acknowledged |
| arb_lost_o | output | 1 | One-cycle pulse on lost arbitration |

## Verification
The read path is driven by a bus-level memory model through a vector table. The table covers single-byte reads, multi-byte reads, a pointer that wraps past 8'hFF, and a zero count. These cases separate correct pointer handoff and the byte order from off-by-one errors in the byte counter and in the ACK/NACK choice on the last byte.

Two NACK vectors cover the two acknowledge slots: one uses a device address that nobody answers, and the other has the slave refuse the word byte. They show that the early STOP skips the repeated start.

A second master on the bus covers both arbitration cases. In one run it pulls SDA low against a released address bit, which must cause an immediate withdrawal with no STOP and leave the bus held busy until that master stops. In the other run it mirrors the block's own bits, which must pass unnoticed.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_TX, ST_TXACK, ST_RX, ST_RXACK, ST_STOP
  } state_e;

  typedef enum logic [1:0] {PH_DEVW, PH_WORD, PH_DEVR, PH_DATA} phase_e;
endpackage

// File: rtl/i2c_rr_sync.sv
module i2c_rr_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q <= '1;
    end else begin
      r_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) r_q[s] <= r_q[s-1];
    end
  end

  assign q_o = r_q[STAGES-1];
endmodule

// File: rtl/i2c_rr_tick.sv
module i2c_rr_tick #(
  parameter int unsigned QDIV = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (QDIV > 1) ? $clog2(QDIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(QDIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i || !en_i || at_end) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && at_end;
endmodule

// File: rtl/i2c_rr_busmon.sv
module i2c_rr_busmon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_o <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (scl_q && scl_i && sda_q && !sda_i)      busy_o <= 1'b1; // START
      else if (scl_q && scl_i && !sda_q && sda_i) busy_o <= 1'b0; // STOP
    end
  end
endmodule

// File: rtl/i2c_rr_master.sv
module i2c_rr_master
  import i2c_rr_pkg::*;
#(
  parameter int unsigned QDIV        = 5,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [6:0]       dev_addr_i,
  input  logic [7:0]       word_addr_i,
  input  logic [CNT_W-1:0] nbytes_i,
  output logic             ready_o,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             nack_o,
  output logic             arb_lost_o
);
  state_e           st_q;
  phase_e           ph_q;
  logic [1:0]       q_q;      // quarter of the current bit symbol
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic [6:0]       dev_q;
  logic [7:0]       word_q;
  logic [CNT_W-1:0] left_q;
  logic             scl_oe_q, sda_oe_q, samp_q, nerr_q;
  logic             scl_s, sda_s, bus_busy, tick, accept, sda_drive;

  i2c_rr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  i2c_rr_busmon u_busmon (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_s), .sda_i(sda_s), .busy_o(bus_busy)
  );

  i2c_rr_tick #(.QDIV(QDIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(st_q != ST_IDLE), .clr_i(accept), .tick_o(tick)
  );

  assign ready_o = (st_q == ST_IDLE) && !bus_busy;
  assign accept  = start_i && ready_o;

  // SDA level set in quarter 1 of each symbol (1 = pull low)
  always_comb begin
    unique case (st_q)
      ST_TX:    sda_drive = ~sh_q[7];
      ST_RXACK: sda_drive = (left_q != CNT_W'(1));
      ST_STOP:  sda_drive = 1'b1;
      default:  sda_drive = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;     ph_q <= PH_DEVW;   q_q <= '0;       bit_q <= '0;
      sh_q <= '0;          dev_q <= '0;       word_q <= '0;    left_q <= '0;
      scl_oe_q <= 1'b0;    sda_oe_q <= 1'b0;  samp_q <= 1'b1;  nerr_q <= 1'b0;
      rd_data_o <= '0;     rd_valid_o <= 1'b0; done_o <= 1'b0;
      nack_o <= 1'b0;      arb_lost_o <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      done_o     <= 1'b0;
      nack_o     <= 1'b0;
      arb_lost_o <= 1'b0;
      if (accept) begin
        st_q     <= ST_START;
        ph_q     <= PH_DEVW;
        q_q      <= '0;
        sh_q     <= {dev_addr_i, 1'b0};
        dev_q    <= dev_addr_i;
        word_q   <= word_addr_i;
        left_q   <= (nbytes_i == '0) ? CNT_W'(1) : nbytes_i;
        nerr_q   <= 1'b0;
        scl_oe_q <= 1'b1;
      end else if (tick) begin
        q_q <= q_q + 2'd1;
        unique case (q_q)
          2'd0: sda_oe_q <= sda_drive;
          2'd1: scl_oe_q <= 1'b0;
          2'd2: begin
            samp_q <= sda_s;
            if (st_q == ST_RX)    sh_q <= {sh_q[6:0], sda_s};
            if (st_q == ST_START) sda_oe_q <= 1'b1;  // SDA falls with SCL high
            if (st_q == ST_STOP)  sda_oe_q <= 1'b0;  // SDA rises with SCL high
            if (st_q == ST_TX && !sda_oe_q && !sda_s) begin
              st_q       <= ST_IDLE;
              q_q        <= '0;
              scl_oe_q   <= 1'b0;
              sda_oe_q   <= 1'b0;
              arb_lost_o <= 1'b1;
            end
          end
          default: begin
            scl_oe_q <= (st_q != ST_STOP);
            unique case (st_q)
              ST_START: begin st_q <= ST_TX; bit_q <= 3'd7; end
              ST_TX: begin
                if (bit_q == 3'd0) st_q <= ST_TXACK;
                else begin bit_q <= bit_q - 3'd1; sh_q <= {sh_q[6:0], 1'b0}; end
              end
              ST_TXACK: begin
                if (samp_q) begin
                  st_q <= ST_STOP; nerr_q <= 1'b1;
                end else begin
                  unique case (ph_q)
                    PH_DEVW: begin ph_q <= PH_WORD; sh_q <= word_q; st_q <= ST_TX; bit_q <= 3'd7; end
                    PH_WORD: begin ph_q <= PH_DEVR; sh_q <= {dev_q, 1'b1}; st_q <= ST_START; end
                    default: begin ph_q <= PH_DATA; st_q <= ST_RX; bit_q <= 3'd7; end
                  endcase
                end
              end
              ST_RX: begin
                if (bit_q == 3'd0) begin
                  st_q <= ST_RXACK; rd_data_o <= sh_q; rd_valid_o <= 1'b1;
                end else bit_q <= bit_q - 3'd1;
              end
              ST_RXACK: begin
                if (left_q == CNT_W'(1)) st_q <= ST_STOP;
                else begin left_q <= left_q - 1'b1; st_q <= ST_RX; bit_q <= 3'd7; end
              end
              ST_STOP: begin st_q <= ST_IDLE; done_o <= 1'b1; nack_o <= nerr_q; end
              default: st_q <= ST_IDLE;
            endcase
          end
        endcase
      end
    end
  end

  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/i2c_rr_master_chk.sv
module i2c_rr_master_chk
  import i2c_rr_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   ready_o,
  input logic   scl_oe_o,
  input logic   sda_oe_o,
  input logic   rd_valid_o,
  input logic   done_o,
  input logic   nack_o,
  input logic   arb_lost_o,
  input state_e st_i
);
  logic in_cond;
  assign in_cond = (st_i == ST_START) || (st_i == ST_STOP);

  AST_READY_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !scl_oe_o && !sda_oe_o); // R1

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, arb_lost_o, rd_valid_o})); // R3

  AST_NACK_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |-> done_o && !rd_valid_o); // R5

  AST_ARB_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_o |-> !scl_oe_o && !sda_oe_o && !done_o); // R6

  AST_SDA_WHILE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) && !arb_lost_o && !in_cond
      |-> scl_oe_o && $past(scl_oe_o)); // R8

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) && !ready_o |=> !scl_oe_o); // R10
endmodule

bind i2c_rr_master i2c_rr_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready_o), .scl_oe_o(scl_oe_o),
  .sda_oe_o(sda_oe_o), .rd_valid_o(rd_valid_o), .done_o(done_o), .nack_o(nack_o),
  .arb_lost_o(arb_lost_o), .st_i(st_q)
);

// File: tb/tb_i2c_rr_master.sv
module tb_i2c_rr_master;
  localparam int QDIV = 5;
  localparam int CNT_W = 4;
  localparam logic [6:0] SLV = 7'h50;
  // {dev, word, count, slave refuses word, expect nack}
  localparam int NV = 6;
  localparam logic [20:0] VEC [NV] = '{
    {7'h50, 8'h00, 4'd1, 1'b0, 1'b0},
    {7'h50, 8'h3F, 4'd3, 1'b0, 1'b0},
    {7'h50, 8'hFE, 4'd4, 1'b0, 1'b0},
    {7'h50, 8'h80, 4'd0, 1'b0, 1'b0},
    {7'h51, 8'h10, 4'd2, 1'b0, 1'b1},
    {7'h50, 8'h10, 4'd2, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [6:0] dev = '0;
  logic [7:0] wa = '0;
  logic [CNT_W-1:0] nb = '0;
  logic ready, scl_oe, sda_oe, rd_valid, done, nack, arb_lost;
  logic [7:0] rd_data;
  logic other_sda = 1'b0, other_mirror = 1'b0, nack_word = 1'b0;
  logic s_drv;
  logic scl_w, sda_w;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | s_drv | other_sda | (other_mirror & sda_oe));

  i2c_rr_master #(.QDIV(QDIV), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dev_addr_i(dev), .word_addr_i(wa),
    .nbytes_i(nb), .ready_o(ready), .scl_i(scl_w), .sda_i(sda_w), .scl_oe_o(scl_oe),
    .sda_oe_o(sda_oe), .rd_data_o(rd_data), .rd_valid_o(rd_valid), .done_o(done),
    .nack_o(nack), .arb_lost_o(arb_lost)
  );

  function automatic logic [7:0] mem_f(input logic [7:0] a);
    return a * 8'd7 + 8'h1B;
  endfunction

  // Bus monitor: conditions, SCL period, read strobes
  logic pscl = 1'b1, psda = 1'b1;
  int cyc = 0, last_rise = 0, last_period = 0;
  int starts = 0, stops = 0, arbs = 0, got_n = 0;
  logic [7:0] got [64];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    pscl <= scl_w;
    psda <= sda_w;
    if (pscl && scl_w && psda && !sda_w) starts <= starts + 1;
    if (pscl && scl_w && !psda && sda_w) stops <= stops + 1;
    if (!pscl && scl_w) begin last_period <= cyc - last_rise; last_rise <= cyc; end
    if (arb_lost) arbs <= arbs + 1;
    if (rd_valid) begin got[got_n % 64] <= rd_data; got_n <= got_n + 1; end
  end

  // Memory slave model
  logic spscl, spsda, act, tx, rw, match, m_ack;
  logic [3:0] rcnt;
  logic [7:0] ssh, txb, ptr, mem_cur, mem_inc;
  logic [1:0] bno;
  int m_acks = 0, m_nacks = 0;
  assign mem_cur = mem_f(ptr);
  assign mem_inc = mem_f(ptr + 8'd1);
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spscl <= 1'b1; spsda <= 1'b1; act <= 1'b0; tx <= 1'b0; rw <= 1'b0; match <= 1'b0;
      m_ack <= 1'b0; rcnt <= '0; ssh <= '0; txb <= '0; ptr <= '0; bno <= '0; s_drv <= 1'b0;
    end else begin
      spscl <= scl_w; spsda <= sda_w;
      if (spscl && scl_w && spsda && !sda_w) begin
        act <= 1'b1; rcnt <= '0; bno <= '0; tx <= 1'b0; s_drv <= 1'b0;
      end else if (spscl && scl_w && !spsda && sda_w) begin
        act <= 1'b0; tx <= 1'b0; s_drv <= 1'b0;
      end else if (act && !spscl && scl_w) begin
        rcnt <= rcnt + 4'd1;
        if (rcnt < 4'd8) ssh <= {ssh[6:0], sda_w};
        else if (tx) begin
          m_ack <= !sda_w;
          if (!sda_w) m_acks <= m_acks + 1; else m_nacks <= m_nacks + 1;
        end
      end else if (act && spscl && !scl_w) begin
        if (rcnt == 4'd8) begin
          if (bno == 2'd0) begin
            match <= (ssh[7:1] == SLV); rw <= ssh[0]; s_drv <= (ssh[7:1] == SLV);
          end else if (!tx) begin
            if (bno == 2'd1) ptr <= ssh;
            s_drv <= !nack_word;
          end else s_drv <= 1'b0;
        end else if (rcnt == 4'd9) begin
          rcnt <= '0;
          bno <= (bno == 2'd3) ? 2'd3 : bno + 2'd1;
          if (bno == 2'd0 && match && rw) begin
            tx <= 1'b1; txb <= mem_cur; s_drv <= !mem_cur[7];
          end else if (tx && m_ack) begin
            ptr <= ptr + 8'd1; txb <= mem_inc; s_drv <= !mem_inc[7];
          end else begin
            tx <= 1'b0; s_drv <= 1'b0;
          end
        end else if (tx && rcnt != 4'd0) s_drv <= !txb[3'(7 - rcnt)];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic run_req(input logic [20:0] v);
    int b_got, b_st, b_sp, b_ack, b_nack, b_arb, n_exp;
    bit seen_done, seen_nack, exp_nack;
    b_got = got_n; b_st = starts; b_sp = stops; b_ack = m_acks; b_nack = m_nacks; b_arb = arbs;
    seen_done = 0; seen_nack = 0;
    exp_nack = v[0];
    nack_word = v[1];
    @(negedge clk);
    dev = v[20:14]; wa = v[13:6]; nb = v[5:2]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!ready, "R10 ready low during own transfer", ready, 0);
    dev = 7'h11; wa = 8'h99; start = 1'b1;   // must be ignored
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 20000 && !seen_done; w++) begin
      @(negedge clk);
      if (done) begin seen_done = 1; seen_nack = nack; end
    end
    n_exp = exp_nack ? 0 : ((v[5:2] == 0) ? 1 : int'(v[5:2]));
    chk(seen_done, "R2 transfer completes", seen_done, 1);
    chk(seen_nack == exp_nack, "R5 nack report", seen_nack, exp_nack);
    chk(got_n - b_got == n_exp, "R3 byte count", got_n - b_got, n_exp);
    for (int i = 0; i < n_exp; i++)
      chk(got[(b_got + i) % 64] == mem_f(v[13:6] + 8'(i)), "R3 byte value",
          got[(b_got + i) % 64], mem_f(v[13:6] + 8'(i)));
    chk(starts - b_st == (exp_nack ? 1 : 2), "R2 START count", starts - b_st, exp_nack ? 1 : 2);
    chk(stops - b_sp == 1, "R2 STOP count", stops - b_sp, 1);
    chk(m_acks - b_ack == (n_exp > 0 ? n_exp - 1 : 0), "R4 master ACKs",
        m_acks - b_ack, n_exp > 0 ? n_exp - 1 : 0);
    chk(m_nacks - b_nack == (n_exp > 0 ? 1 : 0), "R4 final NACK", m_nacks - b_nack, n_exp > 0);
    chk(arbs == b_arb, "R7 no arbitration loss", arbs - b_arb, 0);
    chk(last_period == 4 * QDIV, "R9 SCL period", last_period, 4 * QDIV);
    repeat (4) @(negedge clk);
    chk(ready, "R10 ready after STOP", ready, 1);
    nack_word = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    int b_sp;
    bit seen, drove;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 lines released after reset", {scl_oe, sda_oe}, 0);
    chk(ready && !done && !rd_valid && !arb_lost, "R1 ready, no pulses", ready, 1);

    for (int k = 0; k < NV; k++) run_req(VEC[k]);

    // R7: second master sends identical bits
    other_mirror = 1'b1;
    run_req({7'h50, 8'h22, 4'd2, 1'b0, 1'b0});
    other_mirror = 1'b0;

    // R6: second master pulls SDA low against a released address bit
    @(negedge clk);
    dev = SLV; wa = 8'h05; nb = 4'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 200 && !sda_oe; w++) @(negedge clk);
    other_sda = 1'b1;
    b_sp = stops;
    seen = 0;
    for (int w = 0; w < 2000 && !seen; w++) begin
      @(negedge clk);
      if (done) chk(0, "R6 no done on loss", 1, 0);
      if (arb_lost) begin
        seen = 1;
        chk(!scl_oe && !sda_oe, "R6 lines released on loss", {scl_oe, sda_oe}, 0);
      end
    end
    chk(seen, "R6 arbitration loss flagged", seen, 1);
    @(negedge clk);
    chk(!ready, "R10 bus held by other master", ready, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drove = 0;
    for (int w = 0; w < 30; w++) begin
      @(negedge clk);
      if (scl_oe || sda_oe) drove = 1;
    end
    chk(!drove, "R10 request ignored while bus busy", drove, 0);
    chk(stops == b_sp, "R6 no STOP after loss", stops - b_sp, 0);
    other_sda = 1'b0;  // other master's STOP
    repeat (6) @(negedge clk);
    chk(ready, "R10 bus free after foreign STOP", ready, 1);

    run_req({7'h50, 8'h7F, 4'd2, 1'b0, 1'b0});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule